// File: doc/BRIEF.md
# Dual Data FIFO with Threshold, Overrun and Idle Time-out Status

This block holds the transmit and receive data of a serial peripheral controller: two independent first-in first-out stores of eight 32-bit words each, one feeding the serial engine and one filled by it. Each store offers push and pop strobes, a first-word-fall-through read port, a 4-bit occupancy count and empty and full flags.

Around the two stores sits the status logic that software polls or takes interrupts from:

- A receive threshold flag and a transmit threshold flag, each compared against its own 3-bit setting. The two comparisons point in opposite directions.
- A sticky receive overrun flag, set when a word arrives at a full receive store.
- An idle time-out flag, set when received words sit unread for 64 serial clock periods. A tick input marks each of those periods.
- Self-completing clear requests, one per store, with busy indicators.
- Per-flag interrupt gating.

Top module: `sxf_fifo_pair`

## Requirements
- R1: Each store holds up to 8 words and returns them in push order. Its count ranges from 0 to 8, empty is 1 exactly when the count is 0, and full is 1 exactly when the count is 8. A transmit push while full, without a pop in the same cycle, is ignored.
- R2: `rx_th_flag` is 1 when `rx_count` is strictly greater than `rx_th_sel`, else 0.
- R3: `tx_th_flag` is 1 when `tx_count` is less than or equal to `tx_th_sel`, else 0. After reset this is 1, because the count is 0 and the setting is 0.
- R4: A receive push while the store is full and no pop is present is dropped, and it sets `rx_ovr_flag` on that clock edge. The flag stays 1 until a cycle with `rx_ovr_clr` = 1, and a new drop in that same cycle wins over the clear.
- R5: While the receive store is not empty and no pop occurs, the block counts `sclk_tick` pulses. `rx_tout_flag` is set on the edge that samples the 64th such pulse. A pop on a non-empty receive store restarts the count and clears the flag, `rx_tout_clr` = 1 also clears the flag, and the count saturates so that the flag does not set again until a pop.
- R6: A cycle with `tx_clr_req` or `rx_clr_req` = 1 empties that store on the next edge: count 0, empty 1, full 0.
- R7: After the edge that samples a clear request, that store's busy output is 1 for exactly 3 cycles. `clr_busy` is 1 while either store is busy.
- R8: On a store, pushes and pops are ignored in the request cycle and in the 3 busy cycles that follow.
- R9: A push and a pop in the same cycle on a non-empty store leave the count unchanged and keep word order. On a full receive store this combination is not an overrun.
- R10: Each interrupt output is the AND of its flag and its enable: `irq_tx_th`, `irq_rx_th`, `irq_rx_ovr` and `irq_rx_tout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Write `tx_wdata` into the transmit store |
| tx_wdata | input | 32 | Transmit word to store |
| tx_pop | input | 1 | Remove the head word of the transmit store |
| tx_rdata | output | 32 | Head word of the transmit store |
| tx_count | output | 4 | Transmit occupancy |
| tx_empty | output | 1 | Transmit store empty |
| tx_full | output | 1 | Transmit store full |
| rx_push | input | 1 | Write `rx_wdata` into the receive store |
| rx_wdata | input | 32 | Received word to store |
| rx_pop | input | 1 | Read and remove the head word of the receive store |
| rx_rdata | output | 32 | Head word of the receive store |
| rx_count | output | 4 | Receive occupancy |
| rx_empty | output | 1 | Receive store empty |
| rx_full | output | 1 | Receive store full |
| tx_clr_req | input | 1 | Request to flush the transmit store |
| rx_clr_req | input | 1 | Request to flush the receive store |
| tx_clr_busy | output | 1 | Transmit flush in progress |
| rx_clr_busy | output | 1 | Receive flush in progress |
| clr_busy | output | 1 | Either flush in progress |
| tx_th_sel | input | 3 | Transmit threshold setting |
| rx_th_sel | input | 3 | Receive threshold setting |
| tx_th_flag | output | 1 | Transmit count at or below setting |
| rx_th_flag | output | 1 | Receive count above setting |
| sclk_tick | input | 1 | One pulse per serial clock period |
| rx_ovr_flag | output | 1 | Sticky receive overrun |
| rx_ovr_clr | input | 1 | Write-one clear of the overrun flag |
| rx_tout_flag | output | 1 | Receive idle time-out |
| rx_tout_clr | input | 1 | Write-one clear of the time-out flag |
| ie_tx_th | input | 1 | Enable for transmit threshold interrupt |
| ie_rx_th | input | 1 | Enable for receive threshold interrupt |
| ie_rx_ovr | input | 1 | Enable for overrun interrupt |
| ie_rx_tout | input | 1 | Enable for time-out interrupt |
| irq_tx_th | output | 1 | Gated transmit threshold interrupt |
| irq_rx_th | output | 1 | Gated receive threshold interrupt |
| irq_rx_ovr | output | 1 | Gated overrun interrupt |
| irq_rx_tout | output | 1 | Gated time-out interrupt |

## Verification
The stores are exercised in four ways:

- A fill to full followed by a drain shows ordering and the edges of the count.
- A push while full separates the ignored transmit push from the receive drop that raises the overrun flag.
- A combined push and pop, on a half-filled store and on a full one, separates a steady count from an off-by-one count and from a false overrun.
- Threshold settings just below and at the count separate the strict comparison from the non-strict one.

Tick runs of 63 and 64 pulses, and a pop halfway through a run, show whether the idle count starts, restarts and saturates correctly. A push held high through a flush shows the exact length of the busy window.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
  localparam int unsigned SXF_DATA_W     = 32;
  localparam int unsigned SXF_DEPTH      = 8;
  localparam int unsigned SXF_TH_W       = 3;
  localparam int unsigned SXF_IDLE_TICKS = 64;
  localparam int unsigned SXF_CLR_CYCLES = 3;

  // bits needed to hold the values 0..n
  function automatic int unsigned span_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sxf_fifo.sv
module sxf_fifo #(
  parameter int unsigned DATA_W     = sxf_pkg::SXF_DATA_W,
  parameter int unsigned DEPTH      = sxf_pkg::SXF_DEPTH,
  parameter int unsigned CLR_CYCLES = sxf_pkg::SXF_CLR_CYCLES,
  localparam int unsigned PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W     = sxf_pkg::span_bits(DEPTH),
  localparam int unsigned CLR_W     = sxf_pkg::span_bits(CLR_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              clr_busy
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CLR_W-1:0]  clr_left;
  logic              blocked, pop_ok, push_ok, is_full, is_empty;

  assign clr_busy = (clr_left != '0);
  assign blocked  = clr_req | clr_busy;
  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign pop_ok   = pop & ~is_empty & ~blocked;
  assign push_ok  = push & (~is_full | pop_ok) & ~blocked;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      clr_left <= '0;
    end else if (clr_req) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      clr_left <= CLR_W'(CLR_CYCLES);
    end else begin
      if (clr_busy) clr_left <= clr_left - 1'b1;
      if (push_ok)  wr_ptr   <= ptr_next(wr_ptr);
      if (pop_ok)   rd_ptr   <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sxf_idle_timer.sv
module sxf_idle_timer #(
  parameter int unsigned IDLE_TICKS = sxf_pkg::SXF_IDLE_TICKS,
  localparam int unsigned T_W       = sxf_pkg::span_bits(IDLE_TICKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic occupied,
  input  logic read_evt,
  input  logic flag_clr,
  output logic flag
);
  logic [T_W-1:0] ticks_seen;
  logic           restart, expire;

  assign restart = read_evt | ~occupied;
  assign expire  = ~restart & tick & (ticks_seen == T_W'(IDLE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_seen <= '0;
      flag       <= 1'b0;
    end else begin
      if (restart)
        ticks_seen <= '0;
      else if (tick && ticks_seen != T_W'(IDLE_TICKS))
        ticks_seen <= ticks_seen + 1'b1;

      if (expire)
        flag <= 1'b1;
      else if (read_evt || flag_clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sxf_fifo_pair.sv
module sxf_fifo_pair #(
  parameter int unsigned DATA_W     = sxf_pkg::SXF_DATA_W,
  parameter int unsigned DEPTH      = sxf_pkg::SXF_DEPTH,
  parameter int unsigned TH_W       = sxf_pkg::SXF_TH_W,
  parameter int unsigned IDLE_TICKS = sxf_pkg::SXF_IDLE_TICKS,
  parameter int unsigned CLR_CYCLES = sxf_pkg::SXF_CLR_CYCLES,
  localparam int unsigned CNT_W     = sxf_pkg::span_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_empty,
  output logic              tx_full,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic              tx_clr_req,
  input  logic              rx_clr_req,
  output logic              tx_clr_busy,
  output logic              rx_clr_busy,
  output logic              clr_busy,
  input  logic [TH_W-1:0]   tx_th_sel,
  input  logic [TH_W-1:0]   rx_th_sel,
  output logic              tx_th_flag,
  output logic              rx_th_flag,
  input  logic              sclk_tick,
  output logic              rx_ovr_flag,
  input  logic              rx_ovr_clr,
  output logic              rx_tout_flag,
  input  logic              rx_tout_clr,
  input  logic              ie_tx_th,
  input  logic              ie_rx_th,
  input  logic              ie_rx_ovr,
  input  logic              ie_rx_tout,
  output logic              irq_tx_th,
  output logic              irq_rx_th,
  output logic              irq_rx_ovr,
  output logic              irq_rx_tout
);
  logic rx_drop, rx_read;

  sxf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_CYCLES(CLR_CYCLES)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr_req(tx_clr_req),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_count), .clr_busy(tx_clr_busy)
  );

  sxf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLR_CYCLES(CLR_CYCLES)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr_req(rx_clr_req),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_count), .clr_busy(rx_clr_busy)
  );

  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == CNT_W'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (rx_count == CNT_W'(DEPTH));
  assign clr_busy = tx_clr_busy | rx_clr_busy;

  // opposite senses: receive above setting, transmit at or below
  assign rx_th_flag = (rx_count > CNT_W'(rx_th_sel));
  assign tx_th_flag = (tx_count <= CNT_W'(tx_th_sel));

  // a pop on a full store is always taken, so only push-without-pop drops
  assign rx_drop = rx_push & rx_full & ~rx_pop & ~rx_clr_req & ~rx_clr_busy;
  assign rx_read = rx_pop & ~rx_empty;

  always_ff @(posedge clk) begin
    if (rst)
      rx_ovr_flag <= 1'b0;
    else if (rx_drop)
      rx_ovr_flag <= 1'b1;
    else if (rx_ovr_clr)
      rx_ovr_flag <= 1'b0;
  end

  sxf_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst(rst), .tick(sclk_tick), .occupied(~rx_empty),
    .read_evt(rx_read), .flag_clr(rx_tout_clr), .flag(rx_tout_flag)
  );

  assign irq_tx_th   = tx_th_flag   & ie_tx_th;
  assign irq_rx_th   = rx_th_flag   & ie_rx_th;
  assign irq_rx_ovr  = rx_ovr_flag  & ie_rx_ovr;
  assign irq_rx_tout = rx_tout_flag & ie_rx_tout;
endmodule

// File: rtl/sxf_fifo_pair_chk.sv
module sxf_fifo_pair_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_push,
  input logic             tx_pop,
  input logic             tx_full,
  input logic             tx_clr_req,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             rx_empty,
  input logic             rx_full,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_clr_req,
  input logic             rx_clr_busy,
  input logic             rx_ovr_flag,
  input logic             rx_ovr_clr,
  input logic             rx_tout_flag
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));

  a_r1_tx_full_hold: assert property (@(posedge clk) disable iff (rst)
    tx_push && tx_full && !tx_pop && !tx_clr_req |=> tx_full);

  a_r4_ovr_set: assert property (@(posedge clk) disable iff (rst)
    rx_push && rx_full && !rx_pop && !rx_clr_req && !rx_clr_busy |=> rx_ovr_flag && rx_full);

  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_ovr_flag && !rx_ovr_clr |=> rx_ovr_flag);

  a_r5_read_clears_tout: assert property (@(posedge clk) disable iff (rst)
    rx_pop && !rx_empty |=> !rx_tout_flag);

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    rx_clr_req |=> rx_empty && rx_clr_busy);

  a_r8_busy_holds_count: assert property (@(posedge clk) disable iff (rst)
    rx_clr_busy |=> $stable(rx_count));

  a_r9_count_stable: assert property (@(posedge clk) disable iff (rst)
    rx_push && rx_pop && !rx_empty && !rx_clr_req && !rx_clr_busy |=> $stable(rx_count));
endmodule

bind sxf_fifo_pair sxf_fifo_pair_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full),
  .tx_clr_req(tx_clr_req), .tx_count(tx_count),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_count(rx_count), .rx_clr_req(rx_clr_req), .rx_clr_busy(rx_clr_busy),
  .rx_ovr_flag(rx_ovr_flag), .rx_ovr_clr(rx_ovr_clr), .rx_tout_flag(rx_tout_flag)
);

// File: tb/sxf_fifo_pair_tb_top.sv
module sxf_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_wdata = 0, rx_wdata = 0;
  logic [31:0] tx_rdata, rx_rdata;
  logic [3:0]  tx_count, rx_count;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_clr_req = 0, rx_clr_req = 0;
  logic        tx_clr_busy, rx_clr_busy, clr_busy;
  logic [2:0]  tx_th_sel = 0, rx_th_sel = 0;
  logic        tx_th_flag, rx_th_flag;
  logic        sclk_tick = 0;
  logic        rx_ovr_flag, rx_ovr_clr = 0, rx_tout_flag, rx_tout_clr = 0;
  logic        ie_tx_th = 0, ie_rx_th = 0, ie_rx_ovr = 0, ie_rx_tout = 0;
  logic        irq_tx_th, irq_rx_th, irq_rx_ovr, irq_rx_tout;

  int checks = 0;
  int failures = 0;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sxf_fifo_pair dut_i (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_clr_req(tx_clr_req), .rx_clr_req(rx_clr_req),
    .tx_clr_busy(tx_clr_busy), .rx_clr_busy(rx_clr_busy), .clr_busy(clr_busy),
    .tx_th_sel(tx_th_sel), .rx_th_sel(rx_th_sel),
    .tx_th_flag(tx_th_flag), .rx_th_flag(rx_th_flag),
    .sclk_tick(sclk_tick), .rx_ovr_flag(rx_ovr_flag), .rx_ovr_clr(rx_ovr_clr),
    .rx_tout_flag(rx_tout_flag), .rx_tout_clr(rx_tout_clr),
    .ie_tx_th(ie_tx_th), .ie_rx_th(ie_rx_th), .ie_rx_ovr(ie_rx_ovr), .ie_rx_tout(ie_rx_tout),
    .irq_tx_th(irq_tx_th), .irq_rx_th(irq_rx_th), .irq_rx_ovr(irq_rx_ovr),
    .irq_rx_tout(irq_rx_tout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // advance past one rising edge; inputs change and outputs are read here
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // drivers: predict acceptance and record expected words
  task automatic tx_op(input bit do_push, input logic [31:0] d, input bit do_pop);
    tx_push = do_push; tx_wdata = d; tx_pop = do_pop;
    if (do_push && (tx_q.size() < 8 || (do_pop && tx_q.size() > 0))) tx_q.push_back(d);
    cyc();
    tx_push = 0; tx_pop = 0;
  endtask

  task automatic rx_op(input bit do_push, input logic [31:0] d, input bit do_pop);
    rx_push = do_push; rx_wdata = d; rx_pop = do_pop;
    if (do_push && (rx_q.size() < 8 || (do_pop && rx_q.size() > 0))) rx_q.push_back(d);
    cyc();
    rx_push = 0; rx_pop = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_tick = 1; cyc();
      sclk_tick = 0; cyc();
    end
  endtask

  // monitors: compare the head word at each accepted pop (R1 ordering)
  always @(negedge clk) begin
    if (!rst && tx_pop && !tx_empty && !tx_clr_busy && !tx_clr_req) begin
      if (tx_q.size() == 0) check("R1 tx pop with empty scoreboard", 1, 0);
      else check("R1 tx order", tx_rdata, tx_q.pop_front());
    end
    if (!rst && rx_pop && !rx_empty && !rx_clr_busy && !rx_clr_req) begin
      if (rx_q.size() == 0) check("R1 rx pop with empty scoreboard", 1, 0);
      else check("R1 rx order", rx_rdata, rx_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    check("R1 reset tx_count", tx_count, 0);
    check("R1 reset rx_empty", rx_empty, 1);
    check("R1 reset tx_full", tx_full, 0);
    check("R3 reset tx_th_flag", tx_th_flag, 1);
    check("R2 reset rx_th_flag", rx_th_flag, 0);
    check("R4 reset ovr", rx_ovr_flag, 0);

    // R1 fill and overfill transmit
    for (int i = 0; i < 8; i++) tx_op(1, 32'hA500_0000 + i, 0);
    check("R1 tx_count full", tx_count, 8);
    check("R1 tx_full", tx_full, 1);
    check("R3 flag low at 8", tx_th_flag, 0);
    tx_op(1, 32'hDEAD_BEEF, 0);
    check("R1 tx push on full ignored", tx_count, 8);
    for (int i = 0; i < 5; i++) tx_op(0, 0, 1);
    check("R1 tx_count after pops", tx_count, 3);
    tx_th_sel = 3; #1;
    check("R3 count equal setting", tx_th_flag, 1);
    ie_tx_th = 1; #1;
    check("R10 irq_tx_th enabled", irq_tx_th, 1);
    tx_th_sel = 2; #1;
    check("R3 count above setting", tx_th_flag, 0);
    check("R10 irq_tx_th follows flag", irq_tx_th, 0);
    tx_op(1, 32'h0000_1234, 1);
    check("R9 tx push+pop count", tx_count, 3);
    for (int i = 0; i < 3; i++) tx_op(0, 0, 1);
    check("R1 tx drained empty", tx_empty, 1);

    // receive thresholds
    for (int i = 0; i < 5; i++) rx_op(1, 32'h5A00_0000 + i, 0);
    rx_th_sel = 4; #1;
    check("R2 count above setting", rx_th_flag, 1);
    check("R10 irq_rx_th disabled", irq_rx_th, 0);
    ie_rx_th = 1; #1;
    check("R10 irq_rx_th enabled", irq_rx_th, 1);
    rx_th_sel = 5; #1;
    check("R2 count equal setting", rx_th_flag, 0);
    rx_op(1, 32'h5A00_0010, 1);
    check("R9 rx push+pop count", rx_count, 5);
    for (int i = 0; i < 3; i++) rx_op(1, 32'h5A00_0020 + i, 0);
    check("R1 rx full", rx_full, 1);
    rx_op(1, 32'h5A00_0030, 1);
    check("R9 full push+pop count", rx_count, 8);
    check("R9 full push+pop no overrun", rx_ovr_flag, 0);

    // R4 overrun
    rx_op(1, 32'hBAD0_0000, 0);
    check("R4 drop keeps count", rx_count, 8);
    check("R4 overrun set", rx_ovr_flag, 1);
    check("R10 irq_rx_ovr disabled", irq_rx_ovr, 0);
    ie_rx_ovr = 1; #1;
    check("R10 irq_rx_ovr enabled", irq_rx_ovr, 1);
    cyc();
    check("R4 overrun sticky", rx_ovr_flag, 1);
    rx_ovr_clr = 1; cyc(); rx_ovr_clr = 0;
    check("R4 overrun cleared", rx_ovr_flag, 0);
    rx_op(0, 0, 1);
    rx_op(0, 0, 1);

    // R6 R7 R8 receive clear with push held
    rx_clr_req = 1; rx_q.delete(); cyc(); rx_clr_req = 0;
    check("R6 rx cleared count", rx_count, 0);
    check("R6 rx empty", rx_empty, 1);
    check("R6 rx not full", rx_full, 0);
    check("R7 rx busy 1", rx_clr_busy, 1);
    check("R7 clr_busy 1", clr_busy, 1);
    rx_push = 1; rx_wdata = 32'hCAFE_0000;
    cyc();
    check("R7 rx busy 2", rx_clr_busy, 1);
    check("R8 push ignored 2", rx_count, 0);
    cyc();
    check("R7 rx busy 3", rx_clr_busy, 1);
    check("R8 push ignored 3", rx_count, 0);
    cyc();
    check("R7 rx busy done", rx_clr_busy, 0);
    check("R7 clr_busy done", clr_busy, 0);
    check("R8 push ignored last", rx_count, 0);
    rx_push = 0;
    rx_op(1, 32'hCAFE_0001, 0);
    check("R8 push after busy", rx_count, 1);
    rx_op(0, 0, 1);

    // R6 transmit clear
    tx_op(1, 32'h1, 0); tx_op(1, 32'h2, 0);
    tx_clr_req = 1; tx_q.delete(); cyc(); tx_clr_req = 0;
    check("R6 tx cleared", tx_empty, 1);
    check("R7 clr_busy from tx", clr_busy, 1);
    check("R7 rx busy unaffected", rx_clr_busy, 0);
    repeat (3) cyc();

    // R5 idle time-out
    rx_op(1, 32'h7700_0001, 0);
    ticks(63);
    check("R5 no timeout at 63", rx_tout_flag, 0);
    ticks(1);
    check("R5 timeout at 64", rx_tout_flag, 1);
    check("R10 irq_rx_tout disabled", irq_rx_tout, 0);
    ie_rx_tout = 1; #1;
    check("R10 irq_rx_tout enabled", irq_rx_tout, 1);
    rx_op(0, 0, 1);
    check("R5 read clears timeout", rx_tout_flag, 0);
    rx_op(1, 32'h7700_0002, 0);
    rx_op(1, 32'h7700_0003, 0);
    ticks(40);
    rx_op(0, 0, 1);
    ticks(40);
    check("R5 read restarts count", rx_tout_flag, 0);
    ticks(24);
    check("R5 timeout after restart", rx_tout_flag, 1);
    rx_tout_clr = 1; cyc(); rx_tout_clr = 0;
    check("R5 write clear", rx_tout_flag, 0);
    ticks(10);
    check("R5 saturated no reset", rx_tout_flag, 0);
    rx_op(0, 0, 1);
    check("R1 rx drained", rx_empty, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule